// File: doc/BRIEF.md
# Disturb-Based Cell Recovery Classifier

This block is a recovery engine for a flash page that has produced an error the ECC could not correct. When it is started, it first has the rest of the block's valid data copied to safety, then has the failing page read on purpose a programmable number of times. Each of these reads nudges the threshold voltages of the cells upward. Cells that were already close to the programmed side of the read reference move further than cells that sit in the erased side. The block uses that movement to settle cells whose original reading is ambiguous.

After the disturb phase the block takes a stream of per-cell threshold pairs. Each pair is a 9-bit quantised code captured before the disturb phase and one captured after it. A cell whose pre-disturb code lies within a margin of the reference code is decided by its shift. A large shift means the higher-threshold state and a small shift means the lower one. Every other cell keeps the decision its pre-disturb code already gives. The corrected bits leave in input order, each flagged if it was reclassified. A completion pulse at the end of the page carries the number of reclassified cells. The corrected page is then handed to the ECC outside this block.

Top module: `drc_recovery_top`

## Requirements
- R1: From idle, only a one-cycle `fail_i` (with `abort_i` low) starts recovery. At that edge the four configuration inputs are captured. `fail_i` is ignored while a recovery is in progress, and with no start every request output and `in_ready_o` stay low.
- R2: After a start, `backup_req_o` is held high until `backup_done_i` is seen. `disturb_req_o` and `in_ready_o` stay low during that wait.
- R3: `disturb_req_o` is then held high until exactly the captured disturb count of cycles have had `disturb_ack_i` high. A count of zero skips the disturb phase and opens the cell stream directly.
- R4: A cell whose pre-disturb code b satisfies ref−margin ≤ b ≤ ref+margin is reclassified. The lower bound floors at 0, and the upper bound is computed one bit wider so that it cannot wrap. The shift is after−before, or 0 when after ≤ before. `out_bit_o` is 1, meaning the higher-threshold state, when shift ≥ the shift threshold, and 0 otherwise. `out_reclass_o` is 1 for such a cell.
- R5: A cell outside that window gets `out_bit_o` = 1 when b ≥ ref and 0 otherwise, with `out_reclass_o` = 0.
- R6: Decisions leave one per transfer, in the order the cells were accepted, one cycle after acceptance. The block accepts one cell per cycle while the output is drained, and `out_last_o` marks the cell that came in with `in_last_i`.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the output bit, flag and last marker hold their values.
- R8: After the last cell is accepted, `in_ready_o` stays low. When the last decision is transferred, `done_o` is high for exactly one cycle, with `reclass_count_o` equal to the number of reclassified cells in that page.
- R9: `abort_i` returns the block to idle at the next edge: no request, no pending output and no `done_o`. Abort takes priority over a final output transfer in the same cycle, which then produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fail_i | input | 1 | Uncorrectable-error pulse for the page |
| abort_i | input | 1 | Return to idle |
| cfg_ref_i | input | 9 | Reference threshold code |
| cfg_margin_i | input | 9 | Half width of the ambiguity window |
| cfg_shift_thr_i | input | 9 | Inclusive shift threshold |
| cfg_disturbs_i | input | 20 | Number of disturb reads |
| backup_req_o | output | 1 | Request to back up the block's valid data |
| backup_done_i | input | 1 | Backup finished |
| disturb_req_o | output | 1 | Request disturb reads of the page |
| disturb_ack_i | input | 1 | One disturb read done this cycle |
| in_valid_i | input | 1 | Cell pair valid |
| in_ready_o | output | 1 | Cell pair accepted when valid |
| in_before_i | input | 9 | Pre-disturb threshold code |
| in_after_i | input | 9 | Post-disturb threshold code |
| in_last_i | input | 1 | Last cell of the page |
| out_valid_o | output | 1 | Decision valid |
| out_ready_i | input | 1 | Consumer takes the decision |
| out_bit_o | output | 1 | Decided state, 1 = higher threshold |
| out_reclass_o | output | 1 | Cell was decided by its shift |
| out_last_o | output | 1 | Decision of the last cell |
| done_o | output | 1 | Page finished, one cycle |
| reclass_count_o | output | 16 | Reclassified cells in the page |

## Verification
Two events can coincide in one cycle: an abort and the transfer of the page's final decision. The bench provokes this with a one-cell page. It holds `out_ready_i` low until the decision is pending, then raises it in the same cycle as `abort_i`. It judges the outcome by checking that the decision is still delivered and correct, that `done_o` never follows, and that the block is back in idle. A second overlap, a new `fail_i` arriving while cells are streaming, is pulsed between cells and judged by `backup_req_o` staying low and the page still finishing with the expected count.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_BACKUP  = 3'd1,
    ST_DISTURB = 3'd2,
    ST_STREAM  = 3'd3,
    ST_REPORT  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/drc_rst_sync.sv
module drc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/drc_sequencer.sv
module drc_sequencer
  import drc_pkg::*;
#(
  parameter int TH_W  = 9,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_i,
  input  logic             abort_i,
  input  logic [TH_W-1:0]  cfg_ref_i,
  input  logic [TH_W-1:0]  cfg_margin_i,
  input  logic [TH_W-1:0]  cfg_thr_i,
  input  logic [CNT_W-1:0] cfg_disturbs_i,
  input  logic             backup_done_i,
  input  logic             disturb_ack_i,
  input  logic             last_xfer_i,
  output logic             backup_req_o,
  output logic             disturb_req_o,
  output logic             stream_en_o,
  output logic             start_o,
  output logic             done_o,
  output logic [TH_W-1:0]  ref_o,
  output logic [TH_W-1:0]  margin_o,
  output logic [TH_W-1:0]  thr_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             dcnt_en;
  logic [CNT_W-1:0] target_q;
  logic [TH_W-1:0]  ref_q, margin_q, thr_q;
  logic             start;
  logic             ack_hit;
  logic             final_ack;

  assign start     = (state_q == ST_IDLE) && fail_i && !abort_i;
  assign ack_hit   = (state_q == ST_DISTURB) && disturb_ack_i;
  assign final_ack = ack_hit && ((dcnt_q + CNT_ONE) == target_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_BACKUP;
      ST_BACKUP:  if (backup_done_i) state_d = (target_q == '0) ? ST_STREAM : ST_DISTURB;
      ST_DISTURB: if (final_ack) state_d = ST_STREAM;
      ST_STREAM:  if (last_xfer_i) state_d = ST_REPORT;
      ST_REPORT:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (abort_i) state_d = ST_IDLE;
  end

  always_comb begin
    dcnt_en = start || ack_hit;
    dcnt_d  = start ? '0 : dcnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
    end else if (dcnt_en) begin
      dcnt_q <= dcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      ref_q    <= '0;
      margin_q <= '0;
      thr_q    <= '0;
    end else if (start) begin
      target_q <= cfg_disturbs_i;
      ref_q    <= cfg_ref_i;
      margin_q <= cfg_margin_i;
      thr_q    <= cfg_thr_i;
    end
  end

  assign backup_req_o  = (state_q == ST_BACKUP);
  assign disturb_req_o = (state_q == ST_DISTURB);
  assign stream_en_o   = (state_q == ST_STREAM);
  assign done_o        = (state_q == ST_REPORT);
  assign start_o       = start;
  assign ref_o         = ref_q;
  assign margin_o      = margin_q;
  assign thr_o         = thr_q;
endmodule

// File: rtl/drc_cell_judge.sv
module drc_cell_judge #(
  parameter int TH_W = 9
) (
  input  logic [TH_W-1:0] before_i,
  input  logic [TH_W-1:0] after_i,
  input  logic [TH_W-1:0] ref_i,
  input  logic [TH_W-1:0] margin_i,
  input  logic [TH_W-1:0] thr_i,
  output logic            bit_o,
  output logic            reclass_o
);
  localparam int WIDE_W = TH_W + 1;

  logic [TH_W-1:0]   lower;
  logic [WIDE_W-1:0] upper;
  logic [TH_W-1:0]   shift;
  logic              in_window;
  logic              plain_bit;
  logic              shift_bit;

  always_comb begin
    lower     = (ref_i > margin_i) ? (ref_i - margin_i) : '0;
    upper     = {1'b0, ref_i} + {1'b0, margin_i};
    in_window = (before_i >= lower) && ({1'b0, before_i} <= upper);
    shift     = (after_i > before_i) ? (after_i - before_i) : '0;
    shift_bit = (shift >= thr_i);
    plain_bit = (before_i >= ref_i);
    bit_o     = in_window ? shift_bit : plain_bit;
    reclass_o = in_window;
  end
endmodule

// File: rtl/drc_out_stage.sv
module drc_out_stage #(
  parameter int CELL_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stream_en_i,
  input  logic                  abort_i,
  input  logic                  clear_i,
  input  logic                  in_valid_i,
  input  logic                  in_last_i,
  input  logic                  cell_bit_i,
  input  logic                  cell_reclass_i,
  input  logic                  out_ready_i,
  output logic                  in_ready_o,
  output logic                  out_valid_o,
  output logic                  out_bit_o,
  output logic                  out_reclass_o,
  output logic                  out_last_o,
  output logic                  last_xfer_o,
  output logic [CELL_CNT_W-1:0] count_o
);
  localparam logic [CELL_CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CELL_CNT_W-1:0] CNT_ONE = CELL_CNT_W'(1);

  logic                  valid_q, valid_d;
  logic                  bit_q, reclass_q, last_q;
  logic                  taken_q, taken_d;
  logic [CELL_CNT_W-1:0] cnt_q, cnt_d;
  logic                  cnt_en;
  logic                  accept;
  logic                  xfer;

  assign in_ready_o = stream_en_i && !abort_i && !taken_q && (!valid_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;
  assign xfer       = valid_q && out_ready_i;

  always_comb begin
    valid_d = valid_q;
    if (xfer)   valid_d = 1'b0;
    if (accept) valid_d = 1'b1;
    if (abort_i) valid_d = 1'b0;

    taken_d = taken_q;
    if (accept && in_last_i) taken_d = 1'b1;
    if (clear_i || abort_i)  taken_d = 1'b0;

    cnt_en = clear_i || (accept && cell_reclass_i && (cnt_q != CNT_MAX));
    cnt_d  = clear_i ? '0 : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= 1'b0;
      reclass_q <= 1'b0;
      last_q    <= 1'b0;
    end else if (accept) begin
      bit_q     <= cell_bit_i;
      reclass_q <= cell_reclass_i;
      last_q    <= in_last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign out_valid_o   = valid_q;
  assign out_bit_o     = bit_q;
  assign out_reclass_o = reclass_q;
  assign out_last_o    = last_q;
  assign last_xfer_o   = xfer && last_q;
  assign count_o       = cnt_q;
endmodule

// File: rtl/drc_recovery_top.sv
module drc_recovery_top #(
  parameter int TH_W       = 9,
  parameter int CNT_W      = 20,
  parameter int CELL_CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fail_i,
  input  logic                  abort_i,
  input  logic [TH_W-1:0]       cfg_ref_i,
  input  logic [TH_W-1:0]       cfg_margin_i,
  input  logic [TH_W-1:0]       cfg_shift_thr_i,
  input  logic [CNT_W-1:0]      cfg_disturbs_i,
  output logic                  backup_req_o,
  input  logic                  backup_done_i,
  output logic                  disturb_req_o,
  input  logic                  disturb_ack_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [TH_W-1:0]       in_before_i,
  input  logic [TH_W-1:0]       in_after_i,
  input  logic                  in_last_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic                  out_bit_o,
  output logic                  out_reclass_o,
  output logic                  out_last_o,
  output logic                  done_o,
  output logic [CELL_CNT_W-1:0] reclass_count_o
);
  logic            rst_sync_n;
  logic            stream_en;
  logic            start;
  logic            last_xfer;
  logic [TH_W-1:0] ref_q, margin_q, thr_q;
  logic            cell_bit, cell_reclass;

  drc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  drc_sequencer #(.TH_W(TH_W), .CNT_W(CNT_W)) i_seq (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .fail_i         (fail_i),
    .abort_i        (abort_i),
    .cfg_ref_i      (cfg_ref_i),
    .cfg_margin_i   (cfg_margin_i),
    .cfg_thr_i      (cfg_shift_thr_i),
    .cfg_disturbs_i (cfg_disturbs_i),
    .backup_done_i  (backup_done_i),
    .disturb_ack_i  (disturb_ack_i),
    .last_xfer_i    (last_xfer),
    .backup_req_o   (backup_req_o),
    .disturb_req_o  (disturb_req_o),
    .stream_en_o    (stream_en),
    .start_o        (start),
    .done_o         (done_o),
    .ref_o          (ref_q),
    .margin_o       (margin_q),
    .thr_o          (thr_q)
  );

  drc_cell_judge #(.TH_W(TH_W)) i_judge (
    .before_i  (in_before_i),
    .after_i   (in_after_i),
    .ref_i     (ref_q),
    .margin_i  (margin_q),
    .thr_i     (thr_q),
    .bit_o     (cell_bit),
    .reclass_o (cell_reclass)
  );

  drc_out_stage #(.CELL_CNT_W(CELL_CNT_W)) i_out (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .stream_en_i    (stream_en),
    .abort_i        (abort_i),
    .clear_i        (start),
    .in_valid_i     (in_valid_i),
    .in_last_i      (in_last_i),
    .cell_bit_i     (cell_bit),
    .cell_reclass_i (cell_reclass),
    .out_ready_i    (out_ready_i),
    .in_ready_o     (in_ready_o),
    .out_valid_o    (out_valid_o),
    .out_bit_o      (out_bit_o),
    .out_reclass_o  (out_reclass_o),
    .out_last_o     (out_last_o),
    .last_xfer_o    (last_xfer),
    .count_o        (reclass_count_o)
  );
endmodule

// File: rtl/drc_checker.sv
module drc_checker (
  input logic clk,
  input logic rst_n,
  input logic fail_i,
  input logic abort_i,
  input logic backup_req_o,
  input logic backup_done_i,
  input logic disturb_req_o,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic out_ready_i,
  input logic out_bit_o,
  input logic out_reclass_o,
  input logic out_last_o,
  input logic done_o
);
  AST_START_NEEDS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backup_req_o) |-> $past(fail_i)); // R1

  AST_BACKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    backup_req_o && !backup_done_i && !abort_i |=> backup_req_o); // R2

  AST_NO_DISTURB_IN_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
    backup_req_o |-> !disturb_req_o && !in_ready_o); // R2

  AST_STREAM_AFTER_DISTURB: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> !disturb_req_o && !backup_req_o); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && !abort_i |=>
      out_valid_o && $stable(out_bit_o) && $stable(out_reclass_o) && $stable(out_last_o)); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(out_valid_o && out_ready_i && out_last_o && !abort_i)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !backup_req_o && !disturb_req_o && !in_ready_o && !out_valid_o && !done_o); // R9
endmodule

bind drc_recovery_top drc_checker i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fail_i        (fail_i),
  .abort_i       (abort_i),
  .backup_req_o  (backup_req_o),
  .backup_done_i (backup_done_i),
  .disturb_req_o (disturb_req_o),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_bit_o     (out_bit_o),
  .out_reclass_o (out_reclass_o),
  .out_last_o    (out_last_o),
  .done_o        (done_o)
);

// File: tb/test_drc_recovery_top.sv
`timescale 1ns/1ps
module test_drc_recovery_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fail_i, abort_i;
  logic [8:0]  cfg_ref_i, cfg_margin_i, cfg_shift_thr_i;
  logic [19:0] cfg_disturbs_i;
  logic        backup_req_o, backup_done_i, disturb_req_o, disturb_ack_i;
  logic        in_valid_i, in_ready_o, in_last_i;
  logic [8:0]  in_before_i, in_after_i;
  logic        out_valid_o, out_ready_i, out_bit_o, out_reclass_o, out_last_o;
  logic        done_o;
  logic [15:0] reclass_count_o;

  drc_recovery_top i_drc_recovery_top (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [2:0] expq[$];
  int exp_cnt, ack_cnt, done_seen, prog_disturbs;
  int m_ref, m_margin, m_thr;
  int rdy_mode = 0;
  int cycles = 0;
  int gaps;
  logic [2:0] held;
  bit held_v = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [1:0] model(int b, int a);
    bit win;
    int sh;
    win = (b >= m_ref - m_margin) && (b <= m_ref + m_margin);
    sh  = (a > b) ? a - b : 0;
    if (win) return {(sh >= m_thr), 1'b1};
    return {(b >= m_ref), 1'b0};
  endfunction

  // Reference model, compared on every clock (at the falling edge).
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] cur;
      cur = {out_bit_o, out_reclass_o, out_last_o};
      chk(out_valid_o == (expq.size() != 0), "R6 out_valid", out_valid_o, expq.size() != 0);
      if (held_v && out_valid_o) chk(cur == held, "R7 stall hold", cur, held);
      held_v = out_valid_o && !out_ready_i && !abort_i;
      held   = cur;
      if (out_valid_o && out_ready_i) begin
        if (expq.size() == 0) chk(1'b0, "R6 extra output", 1, 0);
        else begin
          logic [2:0] e;
          e = expq.pop_front();
          if (e[1]) chk(cur == e, "R4 window cell", cur, e);
          else      chk(cur == e, "R5 outside cell", cur, e);
        end
      end
      if (in_valid_i && in_ready_o) begin
        logic [1:0] r;
        r = model(int'(in_before_i), int'(in_after_i));
        expq.push_back({r, in_last_i});
        if (r[0]) exp_cnt++;
      end
      if (disturb_req_o && disturb_ack_i) ack_cnt++;
      if (done_o) begin
        done_seen++;
        chk(reclass_count_o == 16'(exp_cnt), "R8 count", reclass_count_o, exp_cnt);
        chk(expq.size() == 0, "R8 done after drain", expq.size(), 0);
      end
      if (abort_i) expq.delete();
    end
  end

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready_i = 1'b1;
    else if (rdy_mode == 1) out_ready_i = 1'($urandom_range(0, 1));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  task automatic start_page(int r, int m, int t, int nd);
    cfg_ref_i = 9'(r); cfg_margin_i = 9'(m); cfg_shift_thr_i = 9'(t); cfg_disturbs_i = 20'(nd);
    m_ref = r; m_margin = m; m_thr = t; prog_disturbs = nd;
    exp_cnt = 0; ack_cnt = 0; done_seen = 0;
    fail_i = 1'b1;
    @(posedge clk); #1;
    fail_i = 1'b0;
    chk(backup_req_o == 1'b1, "R2 backup req", backup_req_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(backup_req_o && !disturb_req_o && !in_ready_o, "R2 wait for backup", disturb_req_o, 0);
    end
    @(posedge clk); #1;
    backup_done_i = 1'b1;
    @(posedge clk); #1;
    backup_done_i = 1'b0;
    while (disturb_req_o) begin
      disturb_ack_i = 1'($urandom_range(0, 1));
      @(posedge clk); #1;
    end
    disturb_ack_i = 1'b0;
    chk(ack_cnt == prog_disturbs, "R3 disturb count", ack_cnt, prog_disturbs);
    chk(in_ready_o == (rdy_mode != 2 || !out_valid_o), "R3 stream open", in_ready_o, 1);
  endtask

  task automatic send(int b, int a, bit last);
    in_before_i = 9'(b); in_after_i = 9'(a); in_last_i = last; in_valid_i = 1'b1;
    @(negedge clk);
    while (!in_ready_o) begin gaps++; @(negedge clk); end
    @(posedge clk); #1;
    in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (done_seen == 0 && k < 2000) begin @(posedge clk); k++; end
    #1;
    chk(done_seen == 1, "R8 done seen", done_seen, 1);
  endtask

  initial begin
    rst_n = 1'b0; fail_i = 0; abort_i = 0; backup_done_i = 0; disturb_ack_i = 0;
    in_valid_i = 0; in_last_i = 0; in_before_i = 0; in_after_i = 0; out_ready_i = 0;
    cfg_ref_i = 0; cfg_margin_i = 0; cfg_shift_thr_i = 0; cfg_disturbs_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!backup_req_o && !disturb_req_o && !in_ready_o && !out_valid_o && !done_o,
        "R1 reset idle", backup_req_o, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: cells offered while idle are not taken
    in_valid_i = 1'b1; in_before_i = 9'd100; in_after_i = 9'd120;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!in_ready_o && !backup_req_o, "R1 idle no start", in_ready_o, 0);
    end
    @(posedge clk); #1; in_valid_i = 1'b0;

    // Page A: window corners, random stall, fail during stream
    rdy_mode = 1;
    start_page(200, 10, 8, 37);
    send(189, 250, 0); send(190, 198, 0); send(190, 197, 0);
    send(210, 218, 0); send(211, 211, 0); send(199, 190, 0);
    send(200, 207, 0); send(100, 400, 0); send(300, 290, 0);
    @(posedge clk); #1; fail_i = 1'b1;
    @(posedge clk); #1; fail_i = 1'b0;
    chk(!backup_req_o, "R1 fail ignored while busy", backup_req_o, 0);
    for (int i = 0; i < 30; i++) begin
      int b;
      b = 185 + int'($urandom_range(0, 30));
      send(b, b + int'($urandom_range(0, 14)) - 3, i == 29);
    end
    wait_done();

    // Page B: zero disturbs, window floor at 0, threshold 0
    start_page(3, 5, 0, 0);
    send(0, 0, 0); send(8, 5, 0); send(9, 9, 0); send(2, 1, 1);
    wait_done();

    // Page C: abort mid-stream
    start_page(256, 20, 4, 12);
    send(250, 260, 0); send(300, 300, 0); send(240, 241, 0);
    abort_i = 1'b1;
    @(posedge clk); #1;
    abort_i = 1'b0;
    chk(!in_ready_o && !out_valid_o && !backup_req_o && !disturb_req_o,
        "R9 abort to idle", out_valid_o, 0);
    repeat (10) @(posedge clk);
    chk(done_seen == 0, "R9 no done after abort", done_seen, 0);

    // Page D: abort coincides with final transfer
    rdy_mode = 2;
    @(posedge clk); #1; out_ready_i = 1'b0;
    start_page(128, 6, 3, 5);
    send(130, 140, 1);
    in_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!in_ready_o, "R8 no accept after last", in_ready_o, 0);
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0;
    out_ready_i = 1'b1; abort_i = 1'b1;
    @(posedge clk); #1;
    abort_i = 1'b0; out_ready_i = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk(done_seen == 0 && !out_valid_o && !backup_req_o, "R9 abort beats last transfer", done_seen, 0);
    chk(expq.size() == 0, "R9 final decision delivered", expq.size(), 0);

    // Page E: full rate
    rdy_mode = 0;
    @(posedge clk); #1;
    start_page(400, 30, 10, 3);
    gaps = 0;
    for (int i = 0; i < 12; i++) send(370 + i * 5, 380 + i * 6, i == 11);
    chk(gaps == 0, "R6 one cell per cycle", gaps, 0);
    wait_done();

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule